// File: doc/BRIEF.md
# Adapter Reset and Init Sequencer

This block sits beside the glue logic of a network adapter and walks its reset register and two setup registers through fixed, timed write sequences. A host-side controller hands it a two-bit command together with a hold length counted in clock cycles. The block then issues single-cycle register writes on an address/data write port and reports progress with a busy level and a one-cycle done strobe.

The reset register carries three active-low release bits: one for the chip core, one for the host register interface and one for the FIFO. The block keeps a shadow copy of that register, so each write to it alters only the bits that step is meant to change.

It has three commands. Enable releases only the core and then holds. Full initialization briefly asserts all three resets, holds, and then releases them one at a time in a fixed order. It then programs interrupt enables and a FIFO threshold. Shutdown clears the reset register. The bus that carries these writes to the registers is outside the block.

Top module: `adp_init_seq`

## Requirements
- R1: After reset, `busy`, `done` and `wr_en` are 0 and the reset-register shadow is 0, so a first enable command writes exactly 0x04.
- R2: Command code 1 (enable) issues one write to the reset register (address 0) with the core release bit (bit 2) set and the other bits unchanged. It then issues no write for max(N,1) cycles, where N is the accepted hold length, and then signals done.
- R3: Command code 2 (init) first writes the reset register with bit 2 set. In the next cycle it writes the reset register with bits 2, 1 and 0 all cleared.
- R4: After the clearing write of an init, exactly max(N,1) cycles pass with no write before the next write.
- R5: After the hold, init releases the resets with one reset-register write each, in consecutive cycles and in this order: core (bit 2), then host interface (bit 1), then FIFO (bit 0). Each write keeps the bits already released.
- R6: After the FIFO release, init writes 0x0A to the interrupt control register (address 1), which sets the interrupt enable (bit 1) and bus-error enable (bit 3). In the next cycle it writes 30 to the FIFO threshold register (address 2).
- R7: Command code 3 (shutdown) issues a single write of 0x00 to the reset register and then signals done.
- R8: Every reset-register write is formed from the shadow of the previous reset-register writes, so an enable after an init writes 0x07. No reset-register write sets a bit outside bits 2..0.
- R9: `busy` rises in the cycle after a command is accepted and stays high through the done cycle. `done` is high for exactly one cycle, carries no write, and is followed by `busy` low. A run lasts max(N,1)+2 cycles for enable, max(N,1)+8 for init and 2 for shutdown.
- R10: A command is accepted only when `busy` is low and `cmd_op` is non-zero. Commands presented while busy, and code 0, have no effect on the writes or on busy.
- R11: The hold length is sampled when the command is accepted, and later changes on `cmd_wait` do not alter the running hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request strobe |
| cmd_op | input | 2 | Command code: 0 none, 1 enable, 2 init, 3 shutdown |
| cmd_wait | input | WAIT_W | Hold length in cycles, sampled on acceptance |
| busy | output | 1 | A command sequence is in progress |
| done | output | 1 | One-cycle strobe closing a command |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | ADDR_W | Register write address |
| wr_data | output | DATA_W | Register write data |

## Verification
The bench targets a hold length of zero, which a naive counter would turn into a wrap-around wait of tens of thousands of cycles or into a missing hold. It also runs an enable right after an init: a design without the shadow would write 0x04 there and silently re-assert the host and FIFO resets. A command poked mid-run and a change of `cmd_wait` mid-hold catch a design that restarts, or that stretches its hold, from inputs it should have ignored. Comparing write cycles exactly exposes releases that are merged, reordered or shifted by an off-by-one in step advance.

// File: rtl/adp_init_pkg.sv
package adp_init_pkg;

   typedef enum logic [1:0] {
      OP_NONE   = 2'd0,
      OP_ENABLE = 2'd1,
      OP_INIT   = 2'd2,
      OP_SHUT   = 2'd3
   } adp_op_e;

   typedef enum logic [1:0] {
      ST_WRITE = 2'd0,
      ST_HOLD  = 2'd1,
      ST_END   = 2'd2
   } adp_kind_e;

   typedef enum logic [2:0] {
      DM_SET_CORE = 3'd0,
      DM_SET_HOST = 3'd1,
      DM_SET_FIFO = 3'd2,
      DM_CLR_ALL  = 3'd3,
      DM_ZERO     = 3'd4,
      DM_IRQ      = 3'd5,
      DM_THRESH   = 3'd6
   } adp_dsel_e;

   typedef struct packed {
      adp_kind_e kind;
      adp_dsel_e dsel;
   } adp_step_t;

   localparam int STEP_IDX_W = 4;

   function automatic adp_step_t mk_step(adp_kind_e k, adp_dsel_e d);
      adp_step_t s;
      s.kind = k;
      s.dsel = d;
      return s;
   endfunction

endpackage

// File: rtl/adp_step_rom.sv
module adp_step_rom
   import adp_init_pkg::*;
(
   input  adp_op_e                 op,
   input  logic [STEP_IDX_W-1:0]   idx,
   output adp_step_t               step
);

   always_comb begin
      step = mk_step(ST_END, DM_ZERO);
      case (op)
         OP_ENABLE: begin
            case (idx)
               4'd0:    step = mk_step(ST_WRITE, DM_SET_CORE);
               4'd1:    step = mk_step(ST_HOLD,  DM_ZERO);
               default: step = mk_step(ST_END,   DM_ZERO);
            endcase
         end
         OP_INIT: begin
            case (idx)
               4'd0:    step = mk_step(ST_WRITE, DM_SET_CORE);
               4'd1:    step = mk_step(ST_WRITE, DM_CLR_ALL);
               4'd2:    step = mk_step(ST_HOLD,  DM_ZERO);
               4'd3:    step = mk_step(ST_WRITE, DM_SET_CORE);
               4'd4:    step = mk_step(ST_WRITE, DM_SET_HOST);
               4'd5:    step = mk_step(ST_WRITE, DM_SET_FIFO);
               4'd6:    step = mk_step(ST_WRITE, DM_IRQ);
               4'd7:    step = mk_step(ST_WRITE, DM_THRESH);
               default: step = mk_step(ST_END,   DM_ZERO);
            endcase
         end
         OP_SHUT: begin
            case (idx)
               4'd0:    step = mk_step(ST_WRITE, DM_ZERO);
               default: step = mk_step(ST_END,   DM_ZERO);
            endcase
         end
         default: step = mk_step(ST_END, DM_ZERO);
      endcase
   end

endmodule

// File: rtl/adp_wr_mux.sv
module adp_wr_mux
   import adp_init_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter int ADDR_W        = 4,
   parameter int RST_ADDR      = 0,
   parameter int IRQ_ADDR      = 1,
   parameter int THR_ADDR      = 2,
   parameter int CORE_BIT      = 2,
   parameter int HOST_BIT      = 1,
   parameter int FIFO_BIT      = 0,
   parameter int IRQ_EN_BIT    = 1,
   parameter int BUSERR_EN_BIT = 3,
   parameter int THRESH_VAL    = 30
)(
   input  adp_dsel_e           dsel,
   input  logic [DATA_W-1:0]   shadow,
   output logic [ADDR_W-1:0]   addr,
   output logic [DATA_W-1:0]   data,
   output logic                hits_rst
);

   localparam logic [DATA_W-1:0] M_CORE = DATA_W'(1) << CORE_BIT;
   localparam logic [DATA_W-1:0] M_HOST = DATA_W'(1) << HOST_BIT;
   localparam logic [DATA_W-1:0] M_FIFO = DATA_W'(1) << FIFO_BIT;
   localparam logic [DATA_W-1:0] M_ALL  = M_CORE | M_HOST | M_FIFO;
   localparam logic [DATA_W-1:0] M_IRQ  = (DATA_W'(1) << IRQ_EN_BIT) |
                                          (DATA_W'(1) << BUSERR_EN_BIT);
   localparam logic [DATA_W-1:0] V_THR  = DATA_W'(THRESH_VAL);
   localparam logic [ADDR_W-1:0] A_RST  = ADDR_W'(RST_ADDR);
   localparam logic [ADDR_W-1:0] A_IRQ  = ADDR_W'(IRQ_ADDR);
   localparam logic [ADDR_W-1:0] A_THR  = ADDR_W'(THR_ADDR);

   always_comb begin
      addr     = A_RST;
      data     = '0;
      hits_rst = 1'b1;
      case (dsel)
         DM_SET_CORE: data = shadow | M_CORE;
         DM_SET_HOST: data = shadow | M_HOST;
         DM_SET_FIFO: data = shadow | M_FIFO;
         DM_CLR_ALL:  data = shadow & ~M_ALL;
         DM_ZERO:     data = '0;
         DM_IRQ: begin
            addr     = A_IRQ;
            data     = M_IRQ;
            hits_rst = 1'b0;
         end
         DM_THRESH: begin
            addr     = A_THR;
            data     = V_THR;
            hits_rst = 1'b0;
         end
         default: data = '0;
      endcase
   end

endmodule

// File: rtl/adp_hold_timer.sv
module adp_hold_timer #(
   parameter int WAIT_W = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [WAIT_W-1:0] len,
   output logic              expired
);

   logic [WAIT_W-1:0] cnt_q;
   logic [WAIT_W:0]   cnt_next;

   assign cnt_next = {1'b0, cnt_q} + 1'b1;
   assign expired  = run && (cnt_next >= {1'b0, len});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (run && !expired)  cnt_q <= cnt_next[WAIT_W-1:0];
      else                       cnt_q <= '0;
   end

endmodule

// File: rtl/adp_init_seq.sv
module adp_init_seq
   import adp_init_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter int ADDR_W        = 4,
   parameter int WAIT_W        = 16,
   parameter int RST_ADDR      = 0,
   parameter int IRQ_ADDR      = 1,
   parameter int THR_ADDR      = 2,
   parameter int CORE_BIT      = 2,
   parameter int HOST_BIT      = 1,
   parameter int FIFO_BIT      = 0,
   parameter int IRQ_EN_BIT    = 1,
   parameter int BUSERR_EN_BIT = 3,
   parameter int THRESH_VAL    = 30
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [WAIT_W-1:0] cmd_wait,
   output logic              busy,
   output logic              done,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data
);

   localparam int ADDR_SPAN = 1 << ADDR_W;

   if (CORE_BIT >= DATA_W || HOST_BIT >= DATA_W || FIFO_BIT >= DATA_W) begin : g_bad_rel_bit
      $error("release bit outside data width");
   end
   if (CORE_BIT == HOST_BIT || CORE_BIT == FIFO_BIT || HOST_BIT == FIFO_BIT) begin : g_bad_rel_dup
      $error("release bits must be distinct");
   end
   if (IRQ_EN_BIT >= DATA_W || BUSERR_EN_BIT >= DATA_W) begin : g_bad_irq_bit
      $error("interrupt bit outside data width");
   end
   if (THRESH_VAL >= (1 << DATA_W)) begin : g_bad_thresh
      $error("threshold does not fit data width");
   end
   if (RST_ADDR >= ADDR_SPAN || IRQ_ADDR >= ADDR_SPAN || THR_ADDR >= ADDR_SPAN) begin : g_bad_addr
      $error("register address outside address width");
   end
   if (RST_ADDR == IRQ_ADDR || RST_ADDR == THR_ADDR || IRQ_ADDR == THR_ADDR) begin : g_bad_addr_dup
      $error("register addresses must be distinct");
   end

   logic                  running_q;
   adp_op_e               op_q;
   logic [STEP_IDX_W-1:0] idx_q;
   logic [WAIT_W-1:0]     len_q;
   logic [DATA_W-1:0]     shadow_q;

   adp_step_t             step;
   logic                  hold_run;
   logic                  hold_expired;
   logic                  hits_rst;
   logic                  accept;
   logic                  advance;

   adp_step_rom u_rom (
      .op   (op_q),
      .idx  (idx_q),
      .step (step)
   );

   adp_wr_mux #(
      .DATA_W        (DATA_W),
      .ADDR_W        (ADDR_W),
      .RST_ADDR      (RST_ADDR),
      .IRQ_ADDR      (IRQ_ADDR),
      .THR_ADDR      (THR_ADDR),
      .CORE_BIT      (CORE_BIT),
      .HOST_BIT      (HOST_BIT),
      .FIFO_BIT      (FIFO_BIT),
      .IRQ_EN_BIT    (IRQ_EN_BIT),
      .BUSERR_EN_BIT (BUSERR_EN_BIT),
      .THRESH_VAL    (THRESH_VAL)
   ) u_mux (
      .dsel     (step.dsel),
      .shadow   (shadow_q),
      .addr     (wr_addr),
      .data     (wr_data),
      .hits_rst (hits_rst)
   );

   adp_hold_timer #(.WAIT_W(WAIT_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (hold_run),
      .len     (len_q),
      .expired (hold_expired)
   );

   assign accept   = !running_q && cmd_valid && (cmd_op != OP_NONE);
   assign busy     = running_q;
   assign wr_en    = running_q && (step.kind == ST_WRITE);
   assign done     = running_q && (step.kind == ST_END);
   assign hold_run = running_q && (step.kind == ST_HOLD);
   assign advance  = wr_en || (hold_run && hold_expired);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running_q <= 1'b0;
         op_q      <= OP_NONE;
         idx_q     <= '0;
         len_q     <= '0;
      end else if (accept) begin
         running_q <= 1'b1;
         op_q      <= adp_op_e'(cmd_op);
         idx_q     <= '0;
         len_q     <= cmd_wait;
      end else if (done) begin
         running_q <= 1'b0;
      end else if (advance) begin
         idx_q <= idx_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 shadow_q <= '0;
      else if (wr_en && hits_rst) shadow_q <= wr_data;
   end

endmodule

// File: rtl/adp_init_seq_chk.sv
module adp_init_seq_chk #(
   parameter int DATA_W     = 8,
   parameter int ADDR_W     = 4,
   parameter int RST_ADDR   = 0,
   parameter int IRQ_ADDR   = 1,
   parameter int THR_ADDR   = 2,
   parameter int CORE_BIT   = 2,
   parameter int HOST_BIT   = 1,
   parameter int FIFO_BIT   = 0,
   parameter int THRESH_VAL = 30
)(
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic [1:0]        cmd_op,
   input logic              busy,
   input logic              done,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data
);

   localparam logic [DATA_W-1:0] REL_MASK = (DATA_W'(1) << CORE_BIT) |
                                            (DATA_W'(1) << HOST_BIT) |
                                            (DATA_W'(1) << FIFO_BIT);

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9
   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (busy && !wr_en)); // R9
   AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy); // R9
   AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy); // R9
   AST_WR_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> busy); // R9
   AST_NO_START_WITHOUT_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !(cmd_valid && cmd_op != 2'd0)) |=> !busy); // R10
   AST_RST_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(RST_ADDR)) |-> ((wr_data & ~REL_MASK) == '0)); // R8
   AST_THRESH_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(THR_ADDR)) |-> (wr_data == DATA_W'(THRESH_VAL))); // R6
   AST_ADDR_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_addr == ADDR_W'(RST_ADDR) || wr_addr == ADDR_W'(IRQ_ADDR) ||
                 wr_addr == ADDR_W'(THR_ADDR))); // R6

endmodule

bind adp_init_seq adp_init_seq_chk #(
   .DATA_W     (DATA_W),
   .ADDR_W     (ADDR_W),
   .RST_ADDR   (RST_ADDR),
   .IRQ_ADDR   (IRQ_ADDR),
   .THR_ADDR   (THR_ADDR),
   .CORE_BIT   (CORE_BIT),
   .HOST_BIT   (HOST_BIT),
   .FIFO_BIT   (FIFO_BIT),
   .THRESH_VAL (THRESH_VAL)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_op    (cmd_op),
   .busy      (busy),
   .done      (done),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data)
);

// File: tb/adp_init_seq_tb_top.sv
module adp_init_seq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [1:0]  cmd_op = 2'd0;
   logic [15:0] cmd_wait = 16'd0;
   logic        busy, done, wr_en;
   logic [3:0]  wr_addr;
   logic [7:0]  wr_data;

   int checks = 0;
   int errors = 0;

   int e_addr [16];
   int e_data [16];
   int e_cyc  [16];
   int e_n;
   int g_addr [16];
   int g_data [16];
   int g_cyc  [16];
   int g_n;
   int sh_model = 0;

   always #10 clk = ~clk;

   adp_init_seq dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .cmd_wait  (cmd_wait),
      .busy      (busy),
      .done      (done),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic void push(input int a, input int d, input int c);
      e_addr[e_n] = a;
      e_data[e_n] = d;
      e_cyc[e_n]  = c;
      e_n++;
   endfunction

   function automatic string tag_for(input int op, input int i);
      if (op == 1) return "R2 R8";
      if (op == 3) return "R7";
      if (i < 2)   return "R3";
      if (i < 5)   return "R5 R8";
      return "R6";
   endfunction

   // builds expected writes, returns run length; done cycle via ref
   function automatic int build_exp(input int op, input int len, output int done_c);
      int h;
      int base;
      h = (len == 0) ? 1 : len;
      e_n = 0;
      done_c = 0;
      case (op)
         1: begin
            push(0, sh_model | 4, 0);
            sh_model = sh_model | 4;
            done_c = h + 1;
            return h + 2;
         end
         2: begin
            push(0, sh_model | 4, 0);
            sh_model = sh_model | 4;
            push(0, sh_model & ~7, 1);
            sh_model = sh_model & ~7;
            base = 2 + h;
            push(0, sh_model | 4, base);     sh_model = sh_model | 4;
            push(0, sh_model | 2, base + 1); sh_model = sh_model | 2;
            push(0, sh_model | 1, base + 2); sh_model = sh_model | 1;
            push(1, 8'h0A, base + 3);
            push(2, 30, base + 4);
            done_c = base + 5;
            return base + 6;
         end
         default: begin
            push(0, 0, 0);
            sh_model = 0;
            done_c = 1;
            return 2;
         end
      endcase
   endfunction

   task automatic run_cmd(input int op, input int len, input bit poke);
      int total;
      int done_c;
      int c;
      int dones;
      int done_at;
      total = build_exp(op, len, done_c);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_op    = 2'(op);
      cmd_wait  = 16'(len);
      @(negedge clk);
      cmd_valid = 1'b0;
      cmd_wait  = 16'($urandom_range(40, 0));   // R11: change after acceptance
      chk(busy === 1'b1, "R9 busy after accept", int'(busy), 1);
      g_n = 0; c = 0; dones = 0; done_at = -1;
      while (busy === 1'b1 && c < 2000) begin
         if (wr_en === 1'b1 && g_n < 16) begin
            g_addr[g_n] = int'(wr_addr);
            g_data[g_n] = int'(wr_data);
            g_cyc[g_n]  = c;
            g_n++;
         end
         if (done === 1'b1) begin
            dones++;
            done_at = c;
         end
         if (poke && c == 1) begin
            cmd_valid = 1'b1;
            cmd_op    = 2'($urandom_range(3, 1));
         end else begin
            cmd_valid = 1'b0;
         end
         @(negedge clk);
         c++;
      end
      cmd_valid = 1'b0;
      chk(g_n == e_n, poke ? "R10 write count with poke" : "R9 write count", g_n, e_n);
      for (int i = 0; i < e_n && i < g_n; i++) begin
         chk(g_addr[i] == e_addr[i], tag_for(op, i), g_addr[i], e_addr[i]);
         chk(g_data[i] == e_data[i], tag_for(op, i), g_data[i], e_data[i]);
         chk(g_cyc[i] == e_cyc[i],
             (op == 2 && i == 2) ? "R4 R11 hold cycles" : tag_for(op, i),
             g_cyc[i], e_cyc[i]);
      end
      chk(dones == 1, "R9 done pulses", dones, 1);
      chk(done_at == done_c, "R9 done cycle", done_at, done_c);
      chk(c == total, "R9 busy length", c, total);
   endtask

   initial begin
      #(200000 * 20);
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy === 1'b0,  "R1 busy at reset",  int'(busy), 0);
      chk(done === 1'b0,  "R1 done at reset",  int'(done), 0);
      chk(wr_en === 1'b0, "R1 wr_en at reset", int'(wr_en), 0);

      // R10: code 0 is ignored
      cmd_valid = 1'b1; cmd_op = 2'd0; cmd_wait = 16'd4;
      repeat (3) begin
         @(negedge clk);
         chk(busy === 1'b0 && wr_en === 1'b0, "R10 code 0 ignored", int'(busy), 0);
      end
      cmd_valid = 1'b0;

      run_cmd(1, 5, 1'b0);   // R1: first enable writes 0x04
      run_cmd(2, 0, 1'b0);   // R4: zero hold behaves as one cycle
      run_cmd(2, 3, 1'b0);
      run_cmd(1, 1, 1'b0);   // R8: enable after init writes 0x07
      run_cmd(3, 2, 1'b0);   // R7
      run_cmd(2, 4, 1'b1);   // R10: poke mid run
      run_cmd(1, 0, 1'b1);

      for (int k = 0; k < 30; k++) begin
         run_cmd(int'($urandom_range(3, 1)), int'($urandom_range(12, 0)),
                 1'($urandom_range(1, 0)));
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule